// File: doc/BRIEF.md
# Synchronized Multi-Output Clock Distributor

This block turns one fast distribution clock into eight derived output clocks. Each channel either passes the distribution clock straight through or produces a 50% duty-cycle clock from its own even-ratio divider. Each channel also has a start delay counted in whole distribution-clock cycles and an enable. A global output-enable pin and a global enable register bit can turn every channel off at once.

An active-low synchronization input realigns all channels. It is asynchronous and goes through a synchronizer whose stages are part of a fixed four-cycle latency. While the input is held low, every output is forced low. When it is released, every enabled channel restarts from a rising edge, so channels with equal delay settings rise on the same distribution-clock edge. Divide ratio, bypass selection and delay are captured only at a release, so a channel never changes shape in the middle of a run. A channel that has been switched off stays low until the next release, which prevents runt pulses.

The global pin and bit are sampled with the distribution clock. An edge index below counts rising edges of `clk`. "Sampled at edge k" means the value present just before that edge.

Top module: `cdist_top`

## Requirements
- R1: There are eight channels. `ch_byp[i]`=1 selects bypass, where the running output follows `clk` (high in every high phase). `ch_byp[i]`=0 selects the channel's divided clock.
- R2: A divided channel with divide value N (`ch_div` field bits [8:1] give N/2, so bit 0 is ignored, and N ranges over the even values 2 to 510) starts high and repeats N/2 cycles high then N/2 cycles low.
- R3: If `sync_n` is sampled low at edge k, every output is low from edge k+4 and stays low for as long as `sync_n` stays low.
- R4: If `sync_n` is sampled high at edge m after being low, every enabled channel with delay 0 goes high at edge m+4. Bypassed and divided channels rise together.
- R5: A delay value d (0 to 15, in `ch_dly`) moves the channel's first rising edge to edge m+4+d.
- R6: A channel runs only while `ch_en[i]`, `glb_en` and `oe_pin` are all 1. If any of them is sampled 0 at edge f, the output is low from edge f+1.
- R7: A channel that has been turned off stays constant low after its enable returns, and restarts only at the next release.
- R8: The divide value, bypass selection and delay are captured at release. Changing them while a channel runs has no effect on its output.
- R9: During reset every output is low. Reset leaves the synchronizer in the asserted state, so the first high sample of `sync_n` after reset acts as a release per R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Distribution clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_n | input | 1 | Asynchronous active-low synchronization request |
| oe_pin | input | 1 | Global output enable pin, active high |
| glb_en | input | 1 | Global enable register bit |
| ch_en | input | 8 | Per-channel enable |
| ch_byp | input | 8 | Per-channel bypass select (1 = undivided clock) |
| ch_div | input | 72 | Per-channel divide value, 9 bits each, channel i at [9i+8:9i] |
| ch_dly | input | 32 | Per-channel start delay, 4 bits each, channel i at [4i+3:4i] |
| clk_out | output | 8 | Output clocks |

## Verification
The bench checks the exact edges on which outputs fall after a sync request and rise after a release. It uses a mix of bypassed channels, ratio 2, ratio 510 and delays 0 and 15. A design that miscounts the synchronizer stages would shift every channel by a cycle, and one that releases the bypass gate a cycle late would leave bypassed channels behind the divided ones. The bench changes divide, bypass and delay values while channels run, which exposes a design that applies them at once and distorts a running clock. It also turns channels and the global controls off and back on, which catches a design that resumes mid-period instead of waiting for the next release.

// File: rtl/cdist_pkg.sv
package cdist_pkg;
   // Channel sequencing: idle (forced low), waiting out its start delay, running
   typedef enum logic [1:0] {
      CH_IDLE = 2'd0,
      CH_WAIT = 2'd1,
      CH_RUN  = 2'd2
   } ch_state_e;

   // Smallest latency that still leaves a two-flop synchronizer plus one arm stage
   localparam int CD_LATENCY_MIN = 3;
endpackage

// File: rtl/cdist_sync.sv
module cdist_sync #(
   parameter int LATENCY = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sync_n,
   output logic sync_ok,
   output logic rel
);
   // The last stage feeds the per-channel state register, which forms the final latency stage
   localparam int STG = LATENCY - 1;

   logic [STG-1:0] sh;
   logic           last_d;

   // Reset into the asserted state, so the first high sample after reset acts as a release
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh     <= '0;
         last_d <= 1'b0;
      end else begin
         sh     <= {sh[STG-2:0], sync_n};
         last_d <= sh[STG-1];
      end
   end

   assign sync_ok = sh[STG-1];
   assign rel     = sh[STG-1] & ~last_d;
endmodule

// File: rtl/cdist_chan.sv
module cdist_chan
   import cdist_pkg::*;
#(
   parameter int DIV_W = 9,
   parameter int DLY_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sync_ok,
   input  logic             rel,
   input  logic             en,
   input  logic             byp,
   input  logic [DIV_W-1:0] div,
   input  logic [DLY_W-1:0] dly,
   output logic             ck_o,
   output logic             run_o,
   output logic             div_o
);
   localparam int HW = DIV_W - 1;

   ch_state_e      st;
   logic [DLY_W-1:0] dcnt;
   logic           byp_l;
   logic [HW-1:0]  half_l;
   logic [HW-1:0]  half_in;
   logic [HW-1:0]  pc;
   logic           started;
   logic           dq;
   logic           gate;

   // Half period; a zero field behaves as the smallest ratio
   always_comb half_in = (div[DIV_W-1:1] == '0) ? HW'(1) : div[DIV_W-1:1];

   // Sequencing and configuration capture at release
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= CH_IDLE;
         dcnt   <= '0;
         byp_l  <= 1'b0;
         half_l <= HW'(1);
      end else if (!sync_ok || !en) begin
         st   <= CH_IDLE;
         dcnt <= '0;
      end else if (rel) begin
         byp_l  <= byp;
         half_l <= half_in;
         dcnt   <= dly;
         st     <= (dly == '0) ? CH_RUN : CH_WAIT;
      end else if (st == CH_WAIT) begin
         if (dcnt == DLY_W'(1)) st <= CH_RUN;
         dcnt <= dcnt - DLY_W'(1);
      end
   end

   // Divider: first edge after entering run is rising, then N/2 high, N/2 low
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dq      <= 1'b0;
         pc      <= '0;
         started <= 1'b0;
      end else if (st != CH_RUN) begin
         dq      <= 1'b0;
         pc      <= '0;
         started <= 1'b0;
      end else if (!started) begin
         dq      <= 1'b1;
         pc      <= '0;
         started <= 1'b1;
      end else if (pc == half_l - HW'(1)) begin
         dq <= ~dq;
         pc <= '0;
      end else begin
         pc <= pc + HW'(1);
      end
   end

   // Bypass gate changes only while clk is low, so the gated clock has no glitch
   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) gate <= 1'b0;
      else        gate <= (st == CH_RUN);
   end

   assign ck_o  = byp_l ? (clk & gate) : dq;
   assign run_o = (st == CH_RUN);
   assign div_o = dq;
endmodule

// File: rtl/cdist_top.sv
module cdist_top
   import cdist_pkg::*;
#(
   parameter int NCH     = 8,
   parameter int DIV_W   = 9,
   parameter int DLY_W   = 4,
   parameter int LATENCY = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 sync_n,
   input  logic                 oe_pin,
   input  logic                 glb_en,
   input  logic [NCH-1:0]       ch_en,
   input  logic [NCH-1:0]       ch_byp,
   input  logic [NCH*DIV_W-1:0] ch_div,
   input  logic [NCH*DLY_W-1:0] ch_dly,
   output logic [NCH-1:0]       clk_out
);
   if (NCH < 1) begin : g_bad_nch
      $error("cdist_top: NCH must be at least 1");
   end
   if (DIV_W < 2) begin : g_bad_div
      $error("cdist_top: DIV_W must be at least 2");
   end
   if (DLY_W < 1) begin : g_bad_dly
      $error("cdist_top: DLY_W must be at least 1");
   end
   if (LATENCY < CD_LATENCY_MIN) begin : g_bad_lat
      $error("cdist_top: LATENCY below minimum");
   end

   logic           sync_ok;
   logic           rel;
   logic           glb_ok;
   logic [NCH-1:0] run;
   logic [NCH-1:0] div_q;

   assign glb_ok = oe_pin & glb_en;

   cdist_sync #(.LATENCY(LATENCY)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .sync_n  (sync_n),
      .sync_ok (sync_ok),
      .rel     (rel)
   );

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      cdist_chan #(.DIV_W(DIV_W), .DLY_W(DLY_W)) u_ch (
         .clk     (clk),
         .rst_n   (rst_n),
         .sync_ok (sync_ok),
         .rel     (rel),
         .en      (ch_en[i] & glb_ok),
         .byp     (ch_byp[i]),
         .div     (ch_div[i*DIV_W +: DIV_W]),
         .dly     (ch_dly[i*DLY_W +: DLY_W]),
         .ck_o    (clk_out[i]),
         .run_o   (run[i]),
         .div_o   (div_q[i])
      );
   end
endmodule

// File: rtl/cdist_chk.sv
module cdist_chk #(
   parameter int NCH = 8
) (
   input logic           clk,
   input logic           rst_n,
   input logic           sync_n,
   input logic           oe_pin,
   input logic           glb_en,
   input logic [NCH-1:0] run,
   input logic [NCH-1:0] div_q
);
   // Edges since reset, saturating, so no $past reaches before reset
   logic [2:0] cyc;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cyc <= '0;
      else if (cyc != 3'd7) cyc <= cyc + 3'd1;
   end

   // R3: a low sampled four edges ago leaves no channel running
   a_r3_held_low: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc >= 3'd4 && !$past(sync_n, 4)) |-> (run == '0));

   // R4: a channel can only start if sync was high four edges before
   a_r4_start_after_release: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc >= 3'd4 && (run & ~$past(run)) != '0) |-> $past(sync_n, 4));

   // R6: global disable stops every channel at the following edge
   a_r6_global_off: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc >= 3'd1 && !(oe_pin && glb_en)) |=> (run == '0));

   // R2: a divider whose channel was not running drives low
   a_r2_idle_div_low: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc >= 3'd1) |=> ((div_q & ~$past(run)) == '0));
endmodule

bind cdist_top cdist_chk #(.NCH(NCH)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .sync_n (sync_n),
   .oe_pin (oe_pin),
   .glb_en (glb_en),
   .run    (run),
   .div_q  (div_q)
);

// File: tb/sim_cdist_top.sv
`timescale 1ns/1ps
module sim_cdist_top;
   localparam int NCH = 8;
   localparam int DW  = 9;
   localparam int LW  = 4;
   localparam int INF = 1 << 30;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic              rst_n  = 1'b0;
   logic              sync_n = 1'b0;
   logic              oe_pin = 1'b1;
   logic              glb_en = 1'b1;
   logic [NCH-1:0]    ch_en  = '1;
   logic [NCH-1:0]    ch_byp = '0;
   logic [NCH*DW-1:0] ch_div = '0;
   logic [NCH*LW-1:0] ch_dly = '0;
   logic [NCH-1:0]    clk_out;

   cdist_top #(.NCH(NCH), .DIV_W(DW), .DLY_W(LW), .LATENCY(4)) u0 (
      .clk(clk), .rst_n(rst_n), .sync_n(sync_n), .oe_pin(oe_pin), .glb_en(glb_en),
      .ch_en(ch_en), .ch_byp(ch_byp), .ch_div(ch_div), .ch_dly(ch_dly), .clk_out(clk_out)
   );

   int ecnt = 0;
   always @(posedge clk) ecnt <= ecnt + 1;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;

   typedef struct {
      int    e;
      int    ch;
      bit    v;
      string req;
   } item_t;
   item_t sbq[$];

   // Model state captured at each release
   int m_byp[NCH];
   int m_n[NCH];
   int m_start[NCH];
   int m_stop[NCH];

   task automatic chk(bit ok, string req, int ch, int got, int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s ch%0d edge %0d: got %0d expected %0d", req, ch, ecnt, got, exp);
      end
   endtask

   function automatic bit expv(int ch, int e);
      if (e < m_start[ch] || e >= m_stop[ch]) return 1'b0;
      if (m_byp[ch] != 0) return 1'b1;
      return ((e - m_start[ch]) % m_n[ch]) < (m_n[ch] / 2);
   endfunction

   // Called at a negedge: the next edge samples the new sync_n high
   task automatic note_release();
      int m;
      m = ecnt + 1;
      for (int i = 0; i < NCH; i++) begin
         int half;
         half     = int'(ch_div[i*DW+1 +: DW-1]);
         if (half == 0) half = 1;
         m_byp[i] = int'(ch_byp[i]);
         m_n[i]   = 2 * half;
         m_stop[i] = INF;
         m_start[i] = (ch_en[i] && glb_en && oe_pin) ? m + 4 + int'(ch_dly[i*LW +: LW]) : INF;
      end
   endtask

   task automatic note_sync_low();
      for (int i = 0; i < NCH; i++)
         if (m_stop[i] > ecnt + 5) m_stop[i] = ecnt + 5;
   endtask

   task automatic note_off(int ch);
      if (m_stop[ch] > ecnt + 2) m_stop[ch] = ecnt + 2;
   endtask

   // Driver: push expectations for the next n edges, one negedge at a time
   task automatic step(int n, string req);
      for (int k = 0; k < n; k++) begin
         for (int i = 0; i < NCH; i++) begin
            item_t it;
            it.e = ecnt + 1; it.ch = i; it.v = expv(i, ecnt + 1); it.req = req;
            sbq.push_back(it);
         end
         @(negedge clk);
      end
   endtask

   // Monitor: compare in the high phase, 1 ns after each rising edge
   initial begin
      forever begin
         @(posedge clk);
         #1;
         while (sbq.size() > 0 && sbq[0].e <= ecnt) begin
            item_t it;
            it = sbq.pop_front();
            if (it.e == ecnt)
               chk(clk_out[it.ch] == it.v, it.req, it.ch, int'(clk_out[it.ch]), int'(it.v));
         end
      end
   end

   task automatic set_ch(int i, bit byp, int n, int d);
      ch_byp[i]         = byp;
      ch_div[i*DW +: DW] = DW'(n);
      ch_dly[i*LW +: LW] = LW'(d);
   endtask

   initial begin
      for (int i = 0; i < NCH; i++) begin
         m_byp[i] = 0; m_n[i] = 2; m_start[i] = INF; m_stop[i] = INF;
      end
      // R1 R2 R5 mix: bypass, ratios 2..510, delays 0..15
      set_ch(0, 1'b1, 2, 0);
      set_ch(1, 1'b0, 2, 0);
      set_ch(2, 1'b0, 4, 0);
      set_ch(3, 1'b0, 6, 3);
      set_ch(4, 1'b0, 10, 15);
      set_ch(5, 1'b0, 8, 1);
      set_ch(6, 1'b0, 2, 15);
      set_ch(7, 1'b0, 510, 0);

      // R9: outputs low while in reset
      repeat (3) begin
         @(posedge clk); #1;
         chk(clk_out == '0, "R9 reset", 0, int'(clk_out), 0);
      end

      // R9: reset release with sync_n high behaves as a release (R4)
      @(negedge clk);
      rst_n  = 1'b1;
      sync_n = 1'b1;
      note_release();
      step(60, "R1 R2 R4 R5 R9");

      // R8: mid-run configuration changes have no effect
      set_ch(1, 1'b0, 6, 0);
      ch_byp[2] = 1'b1;
      ch_dly[0*LW +: LW] = LW'(5);
      step(30, "R8");

      // R3: sync held low forces all outputs low after four edges
      sync_n = 1'b0;
      note_sync_low();
      step(8, "R3");
      sync_n = 1'b1;
      note_release();
      step(50, "R4 R5 R8 new config");

      // R6: per-channel disable; R7: re-enable does not restart
      ch_en[3] = 1'b0;
      note_off(3);
      step(20, "R6 channel off");
      ch_en[3] = 1'b1;
      step(20, "R7 channel re-enabled");

      // R6: global pin off, R7: stays off after pin returns
      oe_pin = 1'b0;
      for (int i = 0; i < NCH; i++) note_off(i);
      step(8, "R6 pin off");
      oe_pin = 1'b1;
      step(8, "R7 pin back");

      // R6: release while global bit is 0 starts nothing
      glb_en = 1'b0;
      sync_n = 1'b0;
      note_sync_low();
      step(6, "R3");
      sync_n = 1'b1;
      note_release();
      step(15, "R6 global bit off");
      glb_en = 1'b1;
      step(6, "R7 global bit back");

      // Fresh sync pulse restarts everything
      sync_n = 1'b0;
      note_sync_low();
      step(6, "R3");
      sync_n = 1'b1;
      note_release();
      step(30, "R4 restart");

      // R2: full period of the largest ratio
      step(560, "R2 ratio 510");

      repeat (3) @(negedge clk);
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   // Watchdog
   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_err++;
         $display("FAIL watchdog: run did not finish, got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end
endmodule